// File: doc/BRIEF.md
# Write-Through Invalidate Snoop Controller

This block sits between a processor and a shared atomic bus and manages a small direct-mapped cache. Each line holds one data word, a tag and a single valid bit. Lines start out invalid. Processor reads that find a valid line with a matching tag are answered locally. All other reads and every write go out over the bus. A read fill marks the line valid. A write never allocates a line, but it refreshes the stored word when the line is present.

A snoop port watches bus traffic from the other agents. If another agent writes an address that is held valid here, the local copy is dropped. Because of this, any number of caches can share a clean copy of a line, and a write by any one of them removes every other copy.

The processor side uses a valid/ready handshake with back-pressure. The processor raises `cpu_valid` together with the command, address and write data. It must hold all of them steady until it sees `cpu_ready` high at a clock edge, which completes that request. The controller keeps `cpu_ready` low until the answer exists: for a local read hit that is the same cycle, and for anything that uses the bus it is the cycle the bus reports completion. The bus side is a plain request/grant/done exchange. At most one transaction is outstanding at a time.

Top module: `wtsnp_ctrl`

## Requirements
- R1: After reset every line is invalid, and both `bus_req` and `cpu_ready` are low.
- R2: A read whose line is invalid or holds a different tag makes exactly one bus transaction with `bus_we`=0. It returns `bus_rdata` on `cpu_rdata` and leaves the line valid with that tag and word.
- R3: A read whose line is valid with a matching tag raises `cpu_ready` in the same cycle it is presented. It returns the stored word and makes no bus request.
- R4: Every write makes exactly one bus transaction with `bus_we`=1, carrying the request address and data. If the line is present, its stored word becomes the written data.
- R5: A write to a line that is not present leaves it not present, so the next read of that address goes to the bus.
- R6: A snoop with `snp_valid`=1, `snp_we`=1 (a write), a source different from `MY_ID`, and an address whose line is valid with a matching tag clears that line. A snoop with `snp_we`=0 (a read), or one whose tag does not match, changes nothing.
- R7: A snoop whose `snp_src` equals `MY_ID` is ignored.
- R8: When an invalidating snoop and a read hit to the same line happen in the same cycle, the snoop wins. The read is served as a miss over the bus.
- R9: `bus_req` stays high from the start of a request until `bus_gnt`, then drops. The bus address, command and data stay stable for the whole transaction. `cpu_ready` for a bus operation is raised only in the cycle `bus_done` is high.
- R10: Exactly one `cpu_ready` cycle answers each request, and `cpu_ready` is never high while `cpu_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address; low IDX_W bits select the line |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Request completes at this edge |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_ready on a read |
| bus_req | output | 1 | Bus request, held until grant |
| bus_gnt | input | 1 | One-cycle grant |
| bus_we | output | 1 | Bus command: 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_done | input | 1 | One-cycle completion of the granted transaction |
| bus_rdata | input | DATA_W | Read data, valid with bus_done |
| snp_valid | input | 1 | Observed bus transaction present |
| snp_we | input | 1 | Observed type: 1 = write, 0 = read |
| snp_src | input | ID_W | Agent that issued the observed transaction |
| snp_addr | input | ADDR_W | Observed address |

## Verification
The assertions assume a well-behaved environment:
- The processor holds its request stable until it is accepted.
- The bus grants only while `bus_req` is high.
- `bus_done` arrives only after a grant.
- Because the bus is atomic, no other agent's write is snooped while this controller owns the bus.

The stimulus respects these rules. It raises a grant only after it has seen a request, pulses done once per grant, and injects snoops only while the processor is idle or in the first cycle of a new request. That first-cycle case is exactly how the same-cycle priority rule gets exercised. Random addresses are drawn from a few tags over all lines, so that hits, conflict misses and snoop matches all occur often.

// File: rtl/wtsnp_pkg.sv
package wtsnp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2
  } ctl_state_t;
endpackage

// File: rtl/wtsnp_store.sv
module wtsnp_store #(
  parameter int LINES  = 8,
  parameter int TAG_W  = 9,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  a_idx,
  output logic              a_valid,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  output logic              b_valid,
  output logic [TAG_W-1:0]  b_tag,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              upd_en,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic [DATA_W-1:0] upd_data,
  input  logic              inv_en,
  input  logic [IDX_W-1:0]  inv_idx
);
  logic [LINES-1:0]  vld;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    // snoop clear outranks a fill on the same line
    always_ff @(posedge clk) begin
      if (!rst_n) vld[i] <= 1'b0;
      else if (inv_en && inv_idx == IDX_W'(i)) vld[i] <= 1'b0;
      else if (fill_en && fill_idx == IDX_W'(i)) vld[i] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end else if (fill_en && fill_idx == IDX_W'(i)) begin
        tag_q[i]  <= fill_tag;
        data_q[i] <= fill_data;
      end else if (upd_en && upd_idx == IDX_W'(i)) begin
        data_q[i] <= upd_data;
      end
    end
  end

  assign a_valid = vld[a_idx];
  assign a_tag   = tag_q[a_idx];
  assign a_data  = data_q[a_idx];
  assign b_valid = vld[b_idx];
  assign b_tag   = tag_q[b_idx];

  assert_snoop_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en |=> !vld[$past(inv_idx)]);

  assert_fill_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !(inv_en && inv_idx == fill_idx)) |=> vld[$past(fill_idx)]);
endmodule

// File: rtl/wtsnp_snoop.sv
module wtsnp_snoop #(
  parameter int ADDR_W = 12,
  parameter int LINES  = 8,
  parameter int ID_W   = 2,
  parameter int MY_ID  = 0,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              snp_valid,
  input  logic              snp_we,
  input  logic [ID_W-1:0]   snp_src,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic [IDX_W-1:0]  b_idx,
  input  logic              b_valid,
  input  logic [TAG_W-1:0]  b_tag,
  output logic              inv_en,
  output logic [IDX_W-1:0]  inv_idx
);
  logic foreign_wr;

  assign b_idx      = snp_addr[IDX_W-1:0];
  assign foreign_wr = snp_valid && snp_we && (snp_src != ID_W'(MY_ID));
  assign inv_en     = foreign_wr && b_valid && (b_tag == snp_addr[ADDR_W-1:IDX_W]);
  assign inv_idx    = b_idx;
endmodule

// File: rtl/wtsnp_fsm.sv
module wtsnp_fsm
  import wtsnp_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int LINES  = 8,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_done,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [IDX_W-1:0]  a_idx,
  input  logic              a_valid,
  input  logic [TAG_W-1:0]  a_tag,
  input  logic [DATA_W-1:0] a_data,
  input  logic              inv_en,
  input  logic [IDX_W-1:0]  inv_idx,
  output logic              fill_en,
  output logic [IDX_W-1:0]  fill_idx,
  output logic [TAG_W-1:0]  fill_tag,
  output logic [DATA_W-1:0] fill_data,
  output logic              upd_en,
  output logic [IDX_W-1:0]  upd_idx,
  output logic [DATA_W-1:0] upd_data
);
  ctl_state_t        st, st_nx;
  logic              r_we;
  logic [ADDR_W-1:0] r_addr;
  logic [DATA_W-1:0] r_wdata;
  logic [ADDR_W-1:0] cur_addr;
  logic              hit_now;
  logic              capture;

  always_comb begin
    cur_addr = (st == ST_IDLE) ? cpu_addr : r_addr;
    a_idx    = cur_addr[IDX_W-1:0];
    // a snoop clearing this line in the same cycle turns the hit into a miss
    hit_now  = a_valid && (a_tag == cur_addr[ADDR_W-1:IDX_W])
               && !(inv_en && inv_idx == a_idx);

    st_nx     = st;
    capture   = 1'b0;
    cpu_ready = 1'b0;
    cpu_rdata = a_data;
    fill_en   = 1'b0;
    upd_en    = 1'b0;
    fill_idx  = r_addr[IDX_W-1:0];
    fill_tag  = r_addr[ADDR_W-1:IDX_W];
    fill_data = bus_rdata;
    upd_idx   = r_addr[IDX_W-1:0];
    upd_data  = r_wdata;

    case (st)
      ST_IDLE: begin
        if (cpu_valid) begin
          if (!cpu_we && hit_now) begin
            cpu_ready = 1'b1;
          end else begin
            capture = 1'b1;
            st_nx   = ST_REQ;
          end
        end
      end
      ST_REQ: begin
        if (bus_gnt) st_nx = ST_XFER;
      end
      ST_XFER: begin
        if (bus_done) begin
          cpu_ready = 1'b1;
          cpu_rdata = bus_rdata;
          if (!r_we) fill_en = 1'b1;
          else if (hit_now) upd_en = 1'b1;
          st_nx = ST_IDLE;
        end
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      r_we    <= 1'b0;
      r_addr  <= '0;
      r_wdata <= '0;
    end else begin
      st <= st_nx;
      if (capture) begin
        r_we    <= cpu_we;
        r_addr  <= cpu_addr;
        r_wdata <= cpu_wdata;
      end
    end
  end

  assign bus_req   = (st == ST_REQ);
  assign bus_we    = r_we;
  assign bus_addr  = r_addr;
  assign bus_wdata = r_wdata;

  assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> bus_req);

  assert_req_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_gnt |=> !bus_req);

  assert_bus_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && $past(bus_req)) |-> ($stable(bus_addr) && $stable(bus_we)));

  assert_write_on_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && cpu_we) |-> bus_done);

  assert_ready_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_valid);
endmodule

// File: rtl/wtsnp_ctrl.sv
module wtsnp_ctrl #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int LINES  = 8,
  parameter int ID_W   = 2,
  parameter int MY_ID  = 0,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_done,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic              snp_we,
  input  logic [ID_W-1:0]   snp_src,
  input  logic [ADDR_W-1:0] snp_addr
);
  logic [IDX_W-1:0]  a_idx, b_idx, inv_idx, fill_idx, upd_idx;
  logic              a_valid, b_valid, inv_en, fill_en, upd_en;
  logic [TAG_W-1:0]  a_tag, b_tag, fill_tag;
  logic [DATA_W-1:0] a_data, fill_data, upd_data;

  wtsnp_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_idx(a_idx), .a_valid(a_valid), .a_tag(a_tag), .a_data(a_data),
    .b_idx(b_idx), .b_valid(b_valid), .b_tag(b_tag),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag), .fill_data(fill_data),
    .upd_en(upd_en), .upd_idx(upd_idx), .upd_data(upd_data),
    .inv_en(inv_en), .inv_idx(inv_idx)
  );

  wtsnp_snoop #(.ADDR_W(ADDR_W), .LINES(LINES), .ID_W(ID_W), .MY_ID(MY_ID)) u_snoop (
    .snp_valid(snp_valid), .snp_we(snp_we), .snp_src(snp_src), .snp_addr(snp_addr),
    .b_idx(b_idx), .b_valid(b_valid), .b_tag(b_tag),
    .inv_en(inv_en), .inv_idx(inv_idx)
  );

  wtsnp_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_done(bus_done), .bus_rdata(bus_rdata),
    .a_idx(a_idx), .a_valid(a_valid), .a_tag(a_tag), .a_data(a_data),
    .inv_en(inv_en), .inv_idx(inv_idx),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag), .fill_data(fill_data),
    .upd_en(upd_en), .upd_idx(upd_idx), .upd_data(upd_data)
  );

  assert_self_snoop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_src == ID_W'(MY_ID)) |-> !inv_en);
endmodule

// File: tb/wtsnp_ctrl_bench.sv
`timescale 1ns/1ps
module wtsnp_ctrl_bench;
  localparam int AW = 12, DW = 32, NL = 8, IW = 3, IDW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_valid = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_ready;
  logic [DW-1:0] cpu_rdata;
  logic bus_req, bus_we;
  logic bus_gnt = 0, bus_done = 0;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata = '0;
  logic snp_valid = 0, snp_we = 0;
  logic [IDW-1:0] snp_src = '0;
  logic [AW-1:0] snp_addr = '0;

  always #2 clk = ~clk;

  wtsnp_ctrl u_wtsnp_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_done(bus_done), .bus_rdata(bus_rdata),
    .snp_valid(snp_valid), .snp_we(snp_we), .snp_src(snp_src), .snp_addr(snp_addr)
  );

  int n_chk = 0, n_fail = 0, gcount = 0, rdy_count = 0;
  logic [DW-1:0] mem [1 << AW];
  logic          m_vld  [NL];
  logic [AW-IW-1:0] m_tag [NL];
  logic [DW-1:0] m_data [NL];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit model_hit(input logic [AW-1:0] a);
    return m_vld[a[IW-1:0]] && m_tag[a[IW-1:0]] == a[AW-1:IW];
  endfunction

  // foreign write seen on the bus: memory changes, matching copy is dropped
  function automatic void foreign_write(input logic [AW-1:0] a);
    mem[a] = $urandom;
    if (model_hit(a)) m_vld[a[IW-1:0]] = 1'b0;
  endfunction

  // bus responder: grant after a request, then one done pulse
  initial begin
    forever begin
      @(negedge clk);
      if (bus_req) begin
        logic [AW-1:0] ba;
        logic bw;
        logic [DW-1:0] bd;
        repeat ($urandom_range(0, 2)) @(negedge clk);
        ba = bus_addr; bw = bus_we; bd = bus_wdata;
        bus_gnt = 1'b1;
        @(negedge clk);
        bus_gnt = 1'b0;
        repeat ($urandom_range(0, 2)) @(negedge clk);
        bus_rdata = mem[ba];
        if (bw) mem[ba] = bd;
        gcount++;
        bus_done = 1'b1;
        @(negedge clk);
        bus_done = 1'b0;
      end
    end
  end

  // R10 monitor: ready without valid
  always @(negedge clk) begin
    #1;
    if (rst_n && cpu_ready && !cpu_valid)
      chk(1'b0, "R10", "ready while valid low", 1, 0);
  end

  task automatic do_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                       input bit with_snp, input string req);
    bit exp_hit, got;
    logic [DW-1:0] exp_d, rd;
    int g0, nbus, readies;
    @(negedge clk);
    if (with_snp) begin
      snp_valid = 1'b1; snp_we = 1'b1; snp_src = 2'd2; snp_addr = a;
      foreign_write(a);
    end
    exp_hit = model_hit(a);
    exp_d   = exp_hit ? m_data[a[IW-1:0]] : mem[a];
    g0 = gcount;
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    got = 0; readies = 0; rd = '0;
    while (!got) begin
      #1;
      if (cpu_ready) begin got = 1; rd = cpu_rdata; readies++; end
      @(negedge clk);
      snp_valid = 1'b0;
    end
    cpu_valid = 1'b0;
    nbus = gcount - g0;
    chk(readies == 1, "R10", "ready count", readies, 1);
    if (!we) begin
      chk(nbus == (exp_hit ? 0 : 1), req, "bus transactions on read", nbus, exp_hit ? 0 : 1);
      chk(rd == exp_d, req, "read data", rd, exp_d);
      if (!exp_hit) begin
        m_vld[a[IW-1:0]] = 1'b1; m_tag[a[IW-1:0]] = a[AW-1:IW]; m_data[a[IW-1:0]] = exp_d;
      end
    end else begin
      chk(nbus == 1, "R4", "bus transactions on write", nbus, 1);
      chk(mem[a] == wd, "R4", "bus write data", mem[a], wd);
      if (exp_hit) m_data[a[IW-1:0]] = wd;
    end
  endtask

  task automatic snoop(input logic [IDW-1:0] src, input bit we, input logic [AW-1:0] a);
    @(negedge clk);
    snp_valid = 1'b1; snp_we = we; snp_src = src; snp_addr = a;
    if (we && src != 2'd0) foreign_write(a);
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(4 * 200000);
    chk(1'b0, "watchdog", "run did not finish", 0, 1);
    summary();
    $finish;
  end

  initial begin
    logic [AW-1:0] A, B;
    void'($urandom(32'd20240611));
    for (int i = 0; i < (1 << AW); i++) mem[i] = i * 32'h9E3779B1 + 32'h55;
    for (int i = 0; i < NL; i++) begin m_vld[i] = 0; m_tag[i] = '0; m_data[i] = '0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(bus_req == 1'b0, "R1", "bus_req after reset", bus_req, 0);
    chk(cpu_ready == 1'b0, "R1", "cpu_ready after reset", cpu_ready, 0);

    A = 12'h0A5; B = 12'h1A5;            // same line, different tags
    do_op(0, A, 0, 0, "R1");             // first access misses
    do_op(0, A, 0, 0, "R3");             // hit
    do_op(1, A, 32'hCAFE0001, 0, "R4");  // write hit
    do_op(0, A, 0, 0, "R4");             // reads back written word, no bus
    do_op(1, B, 32'hBEEF0002, 0, "R5");  // write miss, no allocate
    do_op(0, B, 0, 0, "R5");             // must miss
    do_op(0, A, 0, 0, "R2");             // conflict miss refills A
    snoop(2'd1, 1, A);
    do_op(0, A, 0, 0, "R6");             // invalidated: new memory data
    snoop(2'd3, 1, B);
    do_op(0, A, 0, 0, "R6");             // tag mismatch: still a hit
    snoop(2'd2, 0, A);
    do_op(0, A, 0, 0, "R6");             // snoop read: still a hit
    snoop(2'd0, 1, A);
    do_op(0, A, 0, 0, "R7");             // own id: still a hit
    do_op(0, A, 0, 1, "R8");             // same-cycle snoop wins
    do_op(0, A, 0, 0, "R9");

    for (int k = 0; k < 400; k++) begin
      logic [AW-1:0] ra;
      int pick;
      ra = {AW'($urandom_range(0, 3)) << IW} | AW'($urandom_range(0, NL - 1));
      pick = $urandom_range(0, 9);
      if (pick < 4) do_op(0, ra, 0, ($urandom_range(0, 7) == 0), "R2");
      else if (pick < 7) do_op(1, ra, $urandom, 0, "R4");
      else snoop(IDW'($urandom_range(0, 3)), $urandom_range(0, 1), ra);
    end
    @(negedge clk); #1;
    chk(bus_req == 1'b0, "R9", "bus idle at end", bus_req, 0);
    summary();
    $finish;
  end
endmodule